// File: doc/BRIEF.md
# Instruction Slot Sequencer with Lookahead

This block steps a stack processor through its instruction stream. Each instruction word carries five 6-bit opcodes. The sequencer spends one cycle fetching a word and then one cycle on each opcode slot, so it has six states in all. Opcodes can change that order in three ways. A conditional opcode can skip the slot after it. A repeat opcode can jump back to the first slot of the same word. When a step would go past the last slot, the sequencer returns to the fetch state.

The instruction and data RAM has a registered address: it captures the address at a clock edge and returns the data during the following cycle. Because of this, the sequencer decides one cycle ahead which state and which opcode come next. From that decision it drives the address the RAM must capture at the coming edge:
- the instruction pointer, when the next cycle is a fetch or a literal;
- otherwise one of two operand addresses, A or B, shared on a single address port.

The block keeps two copies of the instruction word. A working copy shifts right as slots are consumed, so the current opcode is always its lowest field. An untouched copy lets a repeat jump back to slot 1.

Top module: `slot_seq`

## Requirements
- R1: Reset leaves the sequencer in state 0, the fetch state. The state is always in the range 0 to 5. State 0 is always followed by state 1, which executes the opcode in bits [5:0] of the word on `mem_rdata` during the fetch cycle.
- R2: From slot state s, an opcode that is neither a taken skip nor a repeat leads to state s+1. From state 5 it leads to state 0.
- R3: Opcode 0x02 with `cond_flag` low leads from slot state s to state s+2, or to state 0 when s+2 exceeds 5. With `cond_flag` high, opcode 0x02 behaves as R2.
- R4: Opcode 0x03 leads to state 1 of the same word, whose slot 1 opcode is executed again. If `irq_pending` or `rep_expire` is high in that cycle, it leads to state 0 instead.
- R5: `cur_op` gives the opcode of the slot being executed: slot k lies in bits [6k-1:6k-6] of the fetched word. `cur_op` is 0 in the fetch state.
- R6: `nxt_op` gives the opcode that will be executed in the next cycle. It is 0 when the next state is 0.
- R7: When the next state is 0, or `nxt_op` is 0x01 (literal), `ram_addr` equals the instruction-pointer value of the next cycle.
- R8: Otherwise, `ram_addr` equals `b_addr` when `nxt_op` is 0x04, and `a_addr` for every other opcode.
- R9: The instruction pointer advances by one, wrapping at its width, at the end of every fetch cycle and of every cycle that executes opcode 0x01. In all other cycles it holds its value.
- R10: While reset is asserted, `ram_addr` is 0, and the instruction pointer is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rdata | input | 32 | RAM read data (instruction word in fetch state, literal cell in literal slot) |
| irq_pending | input | 1 | Interrupt pending; breaks a repeat |
| rep_expire | input | 1 | Repeat counter expiring; breaks a repeat |
| cond_flag | input | 1 | Condition; low makes opcode 0x02 skip |
| a_addr | input | 8 | Operand address A |
| b_addr | input | 8 | Operand address B |
| state_o | output | 3 | Current state (0 fetch, 1..5 slot) |
| cur_op | output | 6 | Opcode executing now |
| nxt_op | output | 6 | Opcode executing next cycle |
| ram_addr | output | 8 | Address for the RAM to capture at the coming edge |
| ip_o | output | 8 | Instruction pointer |

## Verification
The bench builds the block with 6-bit opcodes, five slots, 32-bit words and an 8-bit address. The small address lets the instruction pointer wrap around the bench's 256-word RAM within the run. The RAM image mixes literals, skips, repeats and B-selects in every slot position, including a skip in slots 4 and 5, a repeat in slot 5, and literals packed back to back. Randomised condition, interrupt and expiry inputs then drive every next-state choice and both exits from a repeat.

// File: rtl/slotseq_pkg.sv
package slotseq_pkg;

   // Kind of step decided one cycle ahead
   typedef enum logic [2:0] {
      STEP_LOAD,   // fetch state -> slot 1 of the freshly read word
      STEP_ADV,    // current slot -> following slot
      STEP_SKIP,   // current slot -> two slots over
      STEP_REP,    // back to slot 1 of the retained word
      STEP_FETCH   // next cycle fetches a new word
   } step_e;

endpackage

// File: rtl/slotseq_next.sv
module slotseq_next
   import slotseq_pkg::*;
#(
   parameter int unsigned OP_W    = 6,
   parameter int unsigned SLOTS   = 5,
   parameter int unsigned ST_W    = 3,
   parameter int unsigned OP_SKIP = 2,
   parameter int unsigned OP_REP  = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [OP_W-1:0] cur_op,
   input  logic            cond_flag,
   input  logic            irq_pending,
   input  logic            rep_expire,
   output logic [ST_W-1:0] state,
   output logic [ST_W-1:0] nxt_state,
   output step_e           step
);

   localparam logic [OP_W-1:0] SKIP_C = OP_SKIP[OP_W-1:0];
   localparam logic [OP_W-1:0] REP_C  = OP_REP[OP_W-1:0];
   localparam logic [ST_W:0]   LAST_C = SLOTS[ST_W:0];
   localparam logic [ST_W-1:0] SLOT1  = {{(ST_W-1){1'b0}}, 1'b1};

   logic [ST_W:0] plus1;
   logic [ST_W:0] plus2;

   assign plus1 = {1'b0, state} + {{ST_W{1'b0}}, 1'b1};
   assign plus2 = {1'b0, state} + {{(ST_W-1){1'b0}}, 2'd2};

   always_comb begin
      step      = STEP_FETCH;
      nxt_state = '0;
      if (state == '0) begin
         step      = STEP_LOAD;
         nxt_state = SLOT1;
      end else if (cur_op == REP_C) begin
         if (!(irq_pending || rep_expire)) begin
            step      = STEP_REP;
            nxt_state = SLOT1;
         end
      end else if ((cur_op == SKIP_C) && !cond_flag) begin
         if (plus2 <= LAST_C) begin
            step      = STEP_SKIP;
            nxt_state = plus2[ST_W-1:0];
         end
      end else if (plus1 <= LAST_C) begin
         step      = STEP_ADV;
         nxt_state = plus1[ST_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= '0;
      else        state <= nxt_state;
   end

   AST_STATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, state} <= LAST_C); // R1
   AST_FETCH_THEN_SLOT1: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && state == '0) |=> (state == SLOT1)); // R1
   AST_REP_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && state != '0 && cur_op == REP_C && !irq_pending && !rep_expire)
      |=> (state == SLOT1)); // R4
   AST_REP_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && state != '0 && cur_op == REP_C && (irq_pending || rep_expire))
      |=> (state == '0)); // R4
   AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && state != '0 && {1'b0, state} < LAST_C && cur_op != REP_C
       && !(cur_op == SKIP_C && !cond_flag))
      |=> ({1'b0, state} == {1'b0, $past(state)} + 1'b1)); // R2

endmodule

// File: rtl/slotseq_word.sv
module slotseq_word
   import slotseq_pkg::*;
#(
   parameter int unsigned OP_W   = 6,
   parameter int unsigned WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  step_e             step,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic [OP_W-1:0]   cur_raw,
   output logic [OP_W-1:0]   nxt_op
);

   localparam int unsigned TAPS = 2;

   logic [WORD_W-1:0] work_q;   // shifted copy
   logic [WORD_W-1:0] keep_q;   // unshifted copy
   logic [OP_W-1:0]   tap [TAPS];

   // tap[0]: opcode one slot over, tap[1]: two slots over
   for (genvar k = 0; k < TAPS; k++) begin : g_tap
      if ((k + 2) * OP_W <= WORD_W) begin : g_fit
         assign tap[k] = work_q[(k+1)*OP_W +: OP_W];
      end else begin : g_none
         assign tap[k] = '0;
      end
   end

   assign cur_raw = work_q[OP_W-1:0];

   always_comb begin
      case (step)
         STEP_LOAD: nxt_op = mem_rdata[OP_W-1:0];
         STEP_ADV:  nxt_op = tap[0];
         STEP_SKIP: nxt_op = tap[1];
         STEP_REP:  nxt_op = keep_q[OP_W-1:0];
         default:   nxt_op = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         work_q <= '0;
         keep_q <= '0;
      end else begin
         case (step)
            STEP_LOAD: begin
               work_q <= mem_rdata;
               keep_q <= mem_rdata;
            end
            STEP_ADV:  work_q <= work_q >> OP_W;
            STEP_SKIP: work_q <= work_q >> (2 * OP_W);
            STEP_REP:  work_q <= keep_q;
            default:   work_q <= work_q;
         endcase
      end
   end

   AST_LOOKAHEAD_OP: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && step != STEP_FETCH) |=> (cur_raw == $past(nxt_op))); // R6

endmodule

// File: rtl/slotseq_addr.sv
module slotseq_addr #(
   parameter int unsigned OP_W   = 6,
   parameter int unsigned ST_W   = 3,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned OP_LIT = 1,
   parameter int unsigned OP_USEB = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              consume,
   input  logic [ST_W-1:0]   nxt_state,
   input  logic [OP_W-1:0]   nxt_op,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [ADDR_W-1:0] b_addr,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [ADDR_W-1:0] ip
);

   localparam logic [OP_W-1:0] LIT_C  = OP_LIT[OP_W-1:0];
   localparam logic [OP_W-1:0] USEB_C = OP_USEB[OP_W-1:0];

   logic [ADDR_W-1:0] ip_d;
   logic              want_ip;

   assign ip_d    = ip + {{(ADDR_W-1){1'b0}}, consume};
   assign want_ip = (nxt_state == '0) || (nxt_op == LIT_C);

   always_comb begin
      if (!rst_n)          ram_addr = '0;
      else if (want_ip)    ram_addr = ip_d;
      else if (nxt_op == USEB_C) ram_addr = b_addr;
      else                 ram_addr = a_addr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ip <= '0;
      else        ip <= ip_d;
   end

   AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && nxt_state == '0) |=> (ip == $past(ram_addr))); // R7
   AST_LIT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && nxt_state != '0 && nxt_op == LIT_C) |=> (ip == $past(ram_addr))); // R7
   AST_IP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (ip == $past(ip) || ip == $past(ip) + 1'b1)); // R9

endmodule

// File: rtl/slot_seq.sv
module slot_seq
   import slotseq_pkg::*;
#(
   parameter int unsigned OP_W    = 6,
   parameter int unsigned SLOTS   = 5,
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned OP_LIT  = 1,
   parameter int unsigned OP_SKIP = 2,
   parameter int unsigned OP_REP  = 3,
   parameter int unsigned OP_USEB = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] mem_rdata,
   input  logic              irq_pending,
   input  logic              rep_expire,
   input  logic              cond_flag,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [ADDR_W-1:0] b_addr,
   output logic [$clog2(SLOTS+1)-1:0] state_o,
   output logic [OP_W-1:0]   cur_op,
   output logic [OP_W-1:0]   nxt_op,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [ADDR_W-1:0] ip_o
);

   localparam int unsigned ST_W = $clog2(SLOTS + 1);
   localparam logic [OP_W-1:0] LIT_C = OP_LIT[OP_W-1:0];

   if (OP_W * SLOTS > WORD_W) begin : g_chk_pack
      $error("slot_seq: SLOTS opcodes of OP_W bits do not fit in WORD_W");
   end
   if (SLOTS < 2) begin : g_chk_slots
      $error("slot_seq: at least two slots are needed");
   end
   if (OP_W < 3) begin : g_chk_opw
      $error("slot_seq: OP_W too narrow for the special codes");
   end

   logic [ST_W-1:0] nxt_state;
   logic [OP_W-1:0] cur_raw;
   step_e           step;
   logic            consume;

   slotseq_next #(
      .OP_W(OP_W), .SLOTS(SLOTS), .ST_W(ST_W),
      .OP_SKIP(OP_SKIP), .OP_REP(OP_REP)
   ) u_next (
      .clk(clk), .rst_n(rst_n), .cur_op(cur_raw), .cond_flag(cond_flag),
      .irq_pending(irq_pending), .rep_expire(rep_expire),
      .state(state_o), .nxt_state(nxt_state), .step(step)
   );

   slotseq_word #(.OP_W(OP_W), .WORD_W(WORD_W)) u_word (
      .clk(clk), .rst_n(rst_n), .step(step), .mem_rdata(mem_rdata),
      .cur_raw(cur_raw), .nxt_op(nxt_op)
   );

   assign cur_op  = (state_o == '0) ? '0 : cur_raw;
   assign consume = (state_o == '0) || (cur_raw == LIT_C);

   slotseq_addr #(
      .OP_W(OP_W), .ST_W(ST_W), .ADDR_W(ADDR_W),
      .OP_LIT(OP_LIT), .OP_USEB(OP_USEB)
   ) u_addr (
      .clk(clk), .rst_n(rst_n), .consume(consume), .nxt_state(nxt_state),
      .nxt_op(nxt_op), .a_addr(a_addr), .b_addr(b_addr),
      .ram_addr(ram_addr), .ip(ip_o)
   );

   AST_FETCH_NO_OP: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && nxt_state == '0) |=> (cur_op == '0)); // R5

endmodule

// File: tb/slot_seq_bench.sv
module slot_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 8;
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int CYCLES = 4000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [31:0]       mem_rdata = '0;
   logic              irq_pending = 1'b0, rep_expire = 1'b0, cond_flag = 1'b0;
   logic [ADDR_W-1:0] a_addr = '0, b_addr = '0;
   logic [2:0]        state_o;
   logic [5:0]        cur_op, nxt_op;
   logic [ADDR_W-1:0] ram_addr, ip_o;

   logic [31:0] mem [DEPTH];
   int checks = 0, failures = 0;
   bit done = 0;

   slot_seq #(.ADDR_W(ADDR_W)) u_slot_seq (
      .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .irq_pending(irq_pending),
      .rep_expire(rep_expire), .cond_flag(cond_flag), .a_addr(a_addr), .b_addr(b_addr),
      .state_o(state_o), .cur_op(cur_op), .nxt_op(nxt_op), .ram_addr(ram_addr), .ip_o(ip_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) mem_rdata <= mem[ram_addr];

   function automatic logic [31:0] pack(int o1, int o2, int o3, int o4, int o5);
      return {2'b00, o5[5:0], o4[5:0], o3[5:0], o2[5:0], o1[5:0]};
   endfunction

   task automatic chk(string tag, int act, int exp, string what);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
      end
   endtask

   // behavioural reference model, compared every cycle
   int    m_state = 0, m_ip = 0;
   int    ops [5];
   string m_tag = "R10";

   always @(negedge clk) begin
      int op, ns, nop, ipn, addr;
      string st;
      logic [31:0] w;
      if (!done) begin
         if (!rst_n) begin
            chk("R10", int'(ram_addr), 0, "ram_addr in reset");
            m_state = 0; m_ip = 0; m_tag = "R10";
         end else begin
            if (m_state == 0) begin
               w = mem[m_ip];
               for (int k = 0; k < 5; k++) ops[k] = int'((w >> (6*k)) & 32'h3F);
               op = 0; ns = 1; st = "R1"; ipn = m_ip + 1;
            end else begin
               op = ops[m_state-1];
               ipn = m_ip + ((op == 1) ? 1 : 0);
               if (op == 3) begin
                  ns = (irq_pending || rep_expire) ? 0 : 1; st = "R4";
               end else if (op == 2 && !cond_flag) begin
                  ns = (m_state + 2 > 5) ? 0 : m_state + 2; st = "R3";
               end else begin
                  ns = (m_state + 1 > 5) ? 0 : m_state + 1; st = "R2";
               end
            end
            ipn = ipn % DEPTH;
            nop = (ns == 0) ? 0 : ops[ns-1];
            if (ns == 0 || nop == 1) addr = ipn;
            else if (nop == 4)       addr = int'(b_addr);
            else                     addr = int'(a_addr);
            chk(m_tag, int'(state_o), m_state, "state");
            chk("R5", int'(cur_op), op, "cur_op");
            chk("R6", int'(nxt_op), nop, "nxt_op");
            chk((ns == 0 || nop == 1) ? "R7" : "R8", int'(ram_addr), addr, "ram_addr");
            chk("R9", int'(ip_o), m_ip, "ip");
            m_state = ns; m_ip = ipn; m_tag = st;
         end
      end
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) begin
         int o[5];
         for (int k = 0; k < 5; k++) o[k] = (i*5 + k*3 + (i >> 2) + i*k) % 9;
         mem[i] = pack(o[0], o[1], o[2], o[3], o[4]);
      end
      mem[0] = pack(5, 1, 4, 9, 1);     // A, lit, B, A, lit in slot 5 (cells 1 and 2)
      mem[1] = 32'h0000_0A5A;
      mem[2] = 32'h0000_1234;
      mem[3] = pack(2, 7, 8, 2, 6);     // skip in slot 1 and slot 4 (R3)
      mem[4] = pack(10, 3, 11, 12, 13); // repeat in slot 2 (R4)
      mem[5] = pack(7, 7, 7, 7, 2);     // skip in slot 5 -> fetch
      mem[6] = pack(1, 1, 1, 1, 1);     // five literals back to back (R7, R9)
      mem[12] = pack(4, 4, 2, 9, 3);    // repeat in slot 5
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      for (int c = 0; c < CYCLES; c++) begin
         @(posedge clk);
         #1;
         cond_flag   = (c < 40) ? 1'b0 : 1'($urandom_range(0, 1));
         irq_pending = (c < 40) ? 1'b0 : ($urandom_range(0, 7) == 0);
         rep_expire  = (c < 20) ? 1'b0 : ($urandom_range(0, 3) == 0);
         a_addr      = ADDR_W'($urandom);
         b_addr      = ADDR_W'($urandom);
      end
      @(negedge clk);
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         done = 1;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule